// File: doc/BRIEF.md
# Oscillator Frequency Measurement Counter

This block estimates the frequency of a fast oscillator by counting its cycles across a fixed window of sixteen periods of a slow reference clock. Two fast clocks come in: an internal RC oscillator and a crystal oscillator. A source-select input picks one of them as the counting clock. The slow reference is synchronized into that counting domain, and its falling edges mark the window. When the window closes, the count is frozen and a ready flag is raised. To get the oscillator frequency, divide the count by sixteen and multiply by the slow-clock frequency.

Four events start a new measurement:
- a one-cycle measure-request strobe;
- the RC oscillator's stable flag rising while the RC oscillator is the main clock source;
- the crystal's stable flag rising while the crystal is the main clock source;
- any change of the main-source select.

Every start event clears the result. A start that arrives during a measurement throws the partial window away and begins again.

All control inputs are taken as synchronous to the selected counting clock. The source select must be changed only while both fast clocks are low or while the block is idle. Clock generation, start-up timers and the glitch-free main clock switch are handled elsewhere.

Top module: `fmc_freq_meter`

## Requirements
- R1: While `rst_n` is low, `meas_count` is 0 and `meas_ready` is 0. After reset the block stays idle, with `meas_ready` low, until a start event occurs.
- R2: Counting uses `clk_rc` when `cnt_src` is 0 and `clk_xt` when `cnt_src` is 1.
- R3: A high `meas_req` on a counting-clock edge starts a measurement.
- R4: A 0-to-1 change of `rc_stable` while `main_sel` is 0 (RC is main source) starts a measurement.
- R5: A 0-to-1 change of `xt_stable` while `main_sel` is 1 (crystal is main source) starts a measurement.
- R6: Any change of `main_sel` starts a measurement. The value of `main_sel` remembered after reset is 0.
- R7: The window opens at the first synchronized falling edge of `slow_clk` after the start event. It closes at the 16th falling edge after that. At the close, `meas_ready` rises and `meas_count` equals 16 × (counting-clock cycles per slow period).
- R8: Once `meas_ready` is high, it stays high and `meas_count` holds its value until the next start event.
- R9: A start event clears `meas_ready` and `meas_count` to 0 on the same clock edge. A start during a running window restarts the window.
- R10: `meas_count` saturates at 2^CNT_W − 1 instead of wrapping.
- R11: A stable-flag rise for the oscillator that is not the main source (for example, `rc_stable` rising while `main_sel` is 1) starts nothing, so a finished result is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_rc | input | 1 | Internal RC oscillator clock |
| clk_xt | input | 1 | Crystal oscillator clock |
| cnt_src | input | 1 | Counting clock select: 0 RC, 1 crystal |
| rc_stable | input | 1 | RC oscillator stable flag |
| xt_stable | input | 1 | Crystal oscillator stable flag |
| main_sel | input | 1 | Main clock source: 0 RC, 1 crystal |
| meas_req | input | 1 | Self-clearing measure request strobe |
| slow_clk | input | 1 | Slow reference clock, asynchronous |
| meas_count | output | CNT_W | Fast-clock cycles in 16 slow periods |
| meas_ready | output | 1 | Measurement complete |

## Verification
The bench drives each of the four start events on its own and checks the exact count against 16 times the clock ratio, for both counting sources. A design that opens the window on the start itself, or that closes it one edge early or late, misses that value by one slow period.

A restart in mid-window must reproduce a full-length count. A design that keeps the partial total reports too much.

A second instance with an 8-bit count runs windows long enough to overflow. A wrapping counter shows a small residue instead of 255.

A stable flag rising for the non-main oscillator must leave a finished result and its ready flag intact. A design that decodes the event without checking `main_sel` would clear them.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

   typedef enum logic [1:0] {
      FMC_IDLE  = 2'd0,
      FMC_ARMED = 2'd1,
      FMC_COUNT = 2'd2,
      FMC_DONE  = 2'd3
   } fmc_state_e;

endpackage

// File: rtl/fmc_clk_sel.sv
// Picks the counting clock. Select changes are expected only while both
// inputs are low or the block is idle.
module fmc_clk_sel (
   input  logic clk_a,
   input  logic clk_b,
   input  logic sel_b,
   output logic clk_o
);
   assign clk_o = sel_b ? clk_b : clk_a;
endmodule

// File: rtl/fmc_edge_sync.sv
// Multi-flop synchronizer plus falling-edge detector for the slow reference.
module fmc_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic fall_pulse
);
   initial begin
      if (STAGES < 2) $error("fmc_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign fall_pulse = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/fmc_start_detect.sv
// Merges the four start sources into a single-cycle start event.
module fmc_start_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic meas_req,
   input  logic rc_stable,
   input  logic xt_stable,
   input  logic main_sel,
   output logic start
);
   logic rc_q, xt_q, sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rc_q  <= 1'b0;
         xt_q  <= 1'b0;
         sel_q <= 1'b0;
      end else begin
         rc_q  <= rc_stable;
         xt_q  <= xt_stable;
         sel_q <= main_sel;
      end
   end

   logic rc_evt, xt_evt, sel_evt;
   assign rc_evt  = rc_stable & ~rc_q & ~main_sel;
   assign xt_evt  = xt_stable & ~xt_q &  main_sel;
   assign sel_evt = main_sel ^ sel_q;
   assign start   = meas_req | rc_evt | xt_evt | sel_evt;
endmodule

// File: rtl/fmc_window_ctr.sv
// Window sequencer and saturating cycle counter.
module fmc_window_ctr
   import fmc_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned WIN_EDGES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             fall,
   output logic [CNT_W-1:0] count,
   output logic             ready
);
   localparam int unsigned EW = $clog2(WIN_EDGES + 1);
   localparam logic [EW-1:0]    LAST_EDGE = EW'(WIN_EDGES - 1);
   localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

   initial begin
      if (CNT_W < 4)     $error("fmc_window_ctr: CNT_W must be at least 4");
      if (WIN_EDGES < 1) $error("fmc_window_ctr: WIN_EDGES must be at least 1");
   end

   fmc_state_e    state;
   logic [EW-1:0] edges;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= FMC_IDLE;
         count <= '0;
         edges <= '0;
         ready <= 1'b0;
      end else if (start) begin
         state <= FMC_ARMED;
         count <= '0;
         edges <= '0;
         ready <= 1'b0;
      end else begin
         case (state)
            FMC_ARMED: begin
               if (fall) begin
                  state <= FMC_COUNT;
                  edges <= '0;
               end
            end
            FMC_COUNT: begin
               if (count != CNT_MAX) count <= count + 1'b1;
               if (fall) begin
                  edges <= edges + 1'b1;
                  if (edges == LAST_EDGE) begin
                     state <= FMC_DONE;
                     ready <= 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fmc_freq_meter.sv
module fmc_freq_meter #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned WIN_EDGES   = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             rst_n,
   input  logic             clk_rc,
   input  logic             clk_xt,
   input  logic             cnt_src,
   input  logic             rc_stable,
   input  logic             xt_stable,
   input  logic             main_sel,
   input  logic             meas_req,
   input  logic             slow_clk,
   output logic [CNT_W-1:0] meas_count,
   output logic             meas_ready
);
   logic cnt_clk;
   logic slow_fall;
   logic start_evt;

   fmc_clk_sel u_clk_sel (
      .clk_a (clk_rc),
      .clk_b (clk_xt),
      .sel_b (cnt_src),
      .clk_o (cnt_clk)
   );

   fmc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (cnt_clk),
      .rst_n      (rst_n),
      .async_in   (slow_clk),
      .fall_pulse (slow_fall)
   );

   fmc_start_detect u_start (
      .clk       (cnt_clk),
      .rst_n     (rst_n),
      .meas_req  (meas_req),
      .rc_stable (rc_stable),
      .xt_stable (xt_stable),
      .main_sel  (main_sel),
      .start     (start_evt)
   );

   fmc_window_ctr #(.CNT_W(CNT_W), .WIN_EDGES(WIN_EDGES)) u_win (
      .clk   (cnt_clk),
      .rst_n (rst_n),
      .start (start_evt),
      .fall  (slow_fall),
      .count (meas_count),
      .ready (meas_ready)
   );
endmodule

// File: rtl/fmc_freq_meter_chk.sv
module fmc_freq_meter_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             fall,
   input logic [CNT_W-1:0] count,
   input logic             ready
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   a_r7_ready_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(fall));

   a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !start) |=> (ready && $stable(count)));

   a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!ready && count == '0));

   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CMAX && !start) |=> (count == CMAX));
endmodule

bind fmc_freq_meter fmc_freq_meter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk   (cnt_clk),
   .rst_n (rst_n),
   .start (start_evt),
   .fall  (slow_fall),
   .count (meas_count),
   .ready (meas_ready)
);

// File: tb/tb_fmc_freq_meter.sv
`timescale 1ns/1ps
module tb_fmc_freq_meter;
   logic rst_n = 1'b0;
   logic clk_rc = 1'b0;
   logic clk_xt = 1'b0;
   logic slow_clk = 1'b0;
   logic cnt_src = 1'b0, rc_stable = 1'b0, xt_stable = 1'b0;
   logic main_sel = 1'b0, meas_req = 1'b0;
   logic [15:0] meas_count;
   logic [7:0]  narrow_count;
   logic        meas_ready, narrow_ready;

   int half_k = 5;          // slow half period = 8*half_k ns, K = 2*half_k
   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk_rc = ~clk_rc;   // 125 MHz
   always #2 clk_xt = ~clk_xt;   // twice as fast
   initial forever #(8 * half_k) slow_clk = ~slow_clk;

   fmc_freq_meter dut (
      .rst_n(rst_n), .clk_rc(clk_rc), .clk_xt(clk_xt), .cnt_src(cnt_src),
      .rc_stable(rc_stable), .xt_stable(xt_stable), .main_sel(main_sel),
      .meas_req(meas_req), .slow_clk(slow_clk),
      .meas_count(meas_count), .meas_ready(meas_ready));

   fmc_freq_meter #(.CNT_W(8)) dut_narrow (
      .rst_n(rst_n), .clk_rc(clk_rc), .clk_xt(clk_xt), .cnt_src(cnt_src),
      .rc_stable(rc_stable), .xt_stable(xt_stable), .main_sel(main_sel),
      .meas_req(meas_req), .slow_clk(slow_clk),
      .meas_count(narrow_count), .meas_ready(narrow_ready));

   task automatic summary_and_finish();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk_rc) begin
      cycles++;
      if (cycles > 190000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
         summary_and_finish();
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_count(input int k, input logic src, input int w);
      int raw = 16 * k * (src ? 2 : 1);
      int lim = (1 << w) - 1;
      return (raw > lim) ? lim : raw;
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk_rc);
   endtask

   // mode 0 request strobe, 1 rc stable, 2 xt stable, 3 main source change
   task automatic do_start(input int mode);
      case (mode)
         0: begin meas_req = 1'b1; step(1); meas_req = 1'b0; end
         1: begin
            if (main_sel) begin main_sel = 1'b0; step(1); end
            rc_stable = 1'b0; step(1); rc_stable = 1'b1; step(1);
         end
         2: begin
            if (!main_sel) begin main_sel = 1'b1; step(1); end
            xt_stable = 1'b0; step(1); xt_stable = 1'b1; step(1);
         end
         default: begin main_sel = ~main_sel; step(1); end
      endcase
   endtask

   task automatic wait_ready(input string req, output bit got);
      got = 1'b0;
      for (int i = 0; i < 40 * half_k + 100; i++) begin
         if (meas_ready) begin got = 1'b1; break; end
         step(1);
      end
      chk(got, req, int'(meas_ready), 1);
   endtask

   task automatic measure(input int hk, input logic src, input int mode, input string req);
      bit got;
      half_k = hk;
      cnt_src = src;
      step(2);
      do_start(mode);
      chk(meas_ready == 1'b0, {req, " (R9 clear)"}, int'(meas_ready), 0);
      wait_ready(req, got);
      if (got) begin
         chk(meas_count == 16'(exp_count(2 * hk, src, 16)), {req, " R7 count"},
             int'(meas_count), exp_count(2 * hk, src, 16));
         chk(narrow_count == 8'(exp_count(2 * hk, src, 8)), {req, " R10 narrow"},
             int'(narrow_count), exp_count(2 * hk, src, 8));
      end
   endtask

   initial begin
      int unsigned seed_val;
      bit got;
      logic [15:0] held;
      seed_val = $urandom(32'd71313);

      step(3);
      chk(meas_count == 0, "R1 reset count", int'(meas_count), 0);
      chk(meas_ready == 0, "R1 reset ready", int'(meas_ready), 0);
      rst_n = 1'b1;
      step(40 * half_k);
      chk(meas_ready == 0, "R1 idle after reset", int'(meas_ready), 0);

      measure(5, 1'b0, 0, "R2 rc source R3 request");
      measure(5, 1'b1, 0, "R2 xt source R3 request");
      measure(6, 1'b0, 1, "R4 rc stable start");
      measure(4, 1'b1, 2, "R5 xt stable start");
      measure(7, 1'b0, 3, "R6 main select change");

      // R8: result held across further slow edges
      held = meas_count;
      step(12 * half_k);
      chk(meas_ready == 1'b1, "R8 ready held", int'(meas_ready), 1);
      chk(meas_count == held, "R8 count held", int'(meas_count), int'(held));

      // R11: rc_stable rise while crystal is main source is ignored
      if (!main_sel) begin main_sel = 1'b1; step(1); wait_ready("R11 setup", got); end
      held = meas_count;
      rc_stable = 1'b0; step(1); rc_stable = 1'b1; step(5);
      chk(meas_ready == 1'b1, "R11 ready untouched", int'(meas_ready), 1);
      chk(meas_count == held, "R11 count untouched", int'(meas_count), int'(held));

      // R9: restart in mid-window yields a full-length count
      half_k = 6; cnt_src = 1'b0; step(2);
      do_start(0);
      step(10 * half_k);
      do_start(0);
      chk(meas_count == 0, "R9 restart clears count", int'(meas_count), 0);
      wait_ready("R9 restart", got);
      if (got) chk(meas_count == 16'(exp_count(12, 1'b0, 16)), "R9 restart count",
                   int'(meas_count), exp_count(12, 1'b0, 16));

      // R10: long window overflows the narrow instance
      measure(20, 1'b1, 0, "R10 saturation");
      chk(narrow_count == 8'hFF, "R10 saturated value", int'(narrow_count), 255);

      for (int t = 0; t < 20; t++) begin
         measure(3 + int'($urandom_range(0, 17)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 3)), "R7 random");
      end

      summary_and_finish();
   end
endmodule